// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one channel of an interval timer. It divides a slow timer clock, given here as a one-cycle enable `tickEn` on the system clock, by a 16-bit count. The count is programmed over a byte-wide write port. A write to the control port selects the channel, the byte access scheme and the waveform mode. Two following writes to the counter port supply the count, low byte first and then high byte.

The channel has two waveforms. Rate-generator mode gives one short low pulse per period, which suits a periodic interrupt request. Square-wave mode splits each period into a high half and a low half, which suits tone generation. A count of zero selects the longest period, 65536 ticks. A count of one is raised to two, because a one-tick period cannot hold both a high level and a low pulse.

The output is a function of registered state only, so it changes just after the clock edge on which a tick or a write is taken.

Top module: `pit_channel`

## Requirements
- R1: After reset `outWave` is 1 and the channel is not counting. Counter-port writes made before any accepted control word are ignored, and the output stays 1 through later ticks.
- R2: A control-port write is accepted when all of these hold: bits 7:6 equal `CHANNEL_ID` (default 0), bits 5:4 are 2'b11, and bits 3:1 are 3'b010 (rate generator) or 3'b011 (square wave). Bit 0 is ignored. Acceptance stops counting, returns the byte pointer to the low byte and holds `outWave` at 1 until a new high byte is written.
- R3: A control-port write with a different channel, any other access code, or any other mode value changes nothing, and a running waveform continues without a break.
- R4: Counter-port writes alternate low byte then high byte. The high-byte write restarts the channel at once with the new count, even in the middle of a period. The first tick after it is tick 1 of the new period. A low-byte write alone does not disturb a running waveform.
- R5: A programmed count of 0 gives a period of 65536 ticks.
- R6: In rate-generator mode with count N, `outWave` is low only after tick k where k mod N = N-1, and is high otherwise. The period is N ticks with exactly one tick low.
- R7: In square-wave mode with an even count N, `outWave` is high for N/2 ticks and then low for N/2 ticks, starting with the high half.
- R8: In square-wave mode with an odd count N, the high half lasts (N+1)/2 ticks and the low half lasts (N-1)/2 ticks.
- R9: A programmed count of 1 behaves exactly as a count of 2.
- R10: The channel advances only on cycles with `tickEn` high. Cycles without a tick leave `outWave` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-cycle enable marking a timer input clock tick |
| wrEn | input | 1 | Write strobe for the byte port |
| wrCtrl | input | 1 | 1 selects the control port, 0 the counter port |
| wrData | input | 8 | Write data byte |
| outWave | output | 1 | Channel output waveform |

## Verification
The hardest case to reach from the ports is the longest period. Its square-wave toggle only appears after 32768 ticks, and it depends on the zero count being widened to 17 bits. The stimulus programs a zero count in square-wave mode and ticks on every clock. The reference model then expects the first toggle exactly at tick 32768. Mid-period restarts and ignored control words are also applied on chosen ticks inside a running period, so the bench can tell a skipped beat from a continued one.

// File: rtl/pit_pkg.sv
package pit_pkg;

  // Strobes from control decode to the counting datapath
  typedef struct packed {
    logic stop;    // accepted control word: halt and latch mode
    logic modeSq;  // mode carried with stop: 1 = square wave
    logic ldLow;   // counter port, low byte
    logic start;   // counter port, high byte: load and run
  } pitStrobeT;

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int CHANNEL_ID = 0,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrCtrl,
  input  logic [BYTE_W-1:0] wrData,
  output pitStrobeT         strb
);

  localparam logic [1:0] SEL_ID   = 2'(CHANNEL_ID);
  localparam logic [1:0] ACC_WORD = 2'b11;
  localparam logic [2:0] MODE_RATE = 3'd2;
  localparam logic [2:0] MODE_SQ   = 3'd3;

  logic armed;     // a valid control word has been seen
  logic ptrHigh;   // next counter byte is the high byte
  logic ctrlHit;
  logic cntWr;
  logic [2:0] modeField;

  assign modeField = wrData[3:1];
  assign ctrlHit = wrEn && wrCtrl && (wrData[7:6] == SEL_ID) &&
                   (wrData[5:4] == ACC_WORD) &&
                   ((modeField == MODE_RATE) || (modeField == MODE_SQ));
  assign cntWr = wrEn && !wrCtrl && armed;

  always_comb begin
    strb.stop   = ctrlHit;
    strb.modeSq = (modeField == MODE_SQ);
    strb.ldLow  = cntWr && !ptrHigh;
    strb.start  = cntWr && ptrHigh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      ptrHigh <= 1'b0;
    end else if (ctrlHit) begin
      armed   <= 1'b1;
      ptrHigh <= 1'b0;
    end else if (cntWr) begin
      ptrHigh <= !ptrHigh;
    end
  end

  // R2: an accepted control word returns the pointer to the low byte
  p_ptr_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlHit |=> !ptrHigh);

  // R3: a rejected control word leaves the sequencing state alone
  p_reject_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrCtrl && !ctrlHit) |=> (ptrHigh == $past(ptrHigh)) && (armed == $past(armed)));

  // R1: counter bytes are never decoded before a control word
  p_no_load_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !(strb.start || strb.ldLow));

endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic [BYTE_W-1:0] wrData,
  input  pitStrobeT         strb,
  output logic              outWave
);

  localparam int CNT_W  = 2 * BYTE_W;
  localparam int SPAN_W = CNT_W + 1;
  localparam logic [SPAN_W-1:0] MAX_SPAN = SPAN_W'(1) << CNT_W;
  localparam logic [SPAN_W-1:0] MIN_SPAN = SPAN_W'(2);
  localparam logic [SPAN_W-1:0] ONE      = SPAN_W'(1);

  logic [BYTE_W-1:0] lowByte;
  logic [SPAN_W-1:0] reload;
  logic [SPAN_W-1:0] cnt;
  logic              running;
  logic              sqMode;
  logic              phaseHi;
  logic [CNT_W-1:0]  rawCount;
  logic [SPAN_W-1:0] newSpan;

  assign rawCount = {wrData, lowByte};

  // Zero means the full span; one is raised to the minimum legal span
  always_comb begin
    if (rawCount == '0)
      newSpan = MAX_SPAN;
    else if (rawCount == CNT_W'(1))
      newSpan = MIN_SPAN;
    else
      newSpan = SPAN_W'(rawCount);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lowByte <= '0;
    else if (strb.ldLow)
      lowByte <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload  <= MIN_SPAN;
      cnt     <= '0;
      running <= 1'b0;
      sqMode  <= 1'b0;
      phaseHi <= 1'b1;
    end else if (strb.stop) begin
      running <= 1'b0;
      sqMode  <= strb.modeSq;
      phaseHi <= 1'b1;
    end else if (strb.start) begin
      reload  <= newSpan;
      running <= 1'b1;
      phaseHi <= 1'b1;
      cnt     <= sqMode ? ((newSpan + ONE) >> 1) : newSpan;
    end else if (tickEn && running) begin
      if (cnt == ONE) begin
        if (sqMode) begin
          phaseHi <= !phaseHi;
          cnt     <= phaseHi ? (reload >> 1) : ((reload + ONE) >> 1);
        end else begin
          cnt <= reload;
        end
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  assign outWave = !running || (sqMode ? phaseHi : (cnt != ONE));

  // R2: a stopped channel drives its output high
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> outWave);

  // R6: the rate pulse lasts a single tick
  p_rate_pulse_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !sqMode && !outWave && tickEn && !strb.stop && !strb.start) |=> outWave);

  // R7: the square wave flips level when a half expires
  p_sq_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sqMode && tickEn && (cnt == ONE) && !strb.stop && !strb.start)
      |=> (outWave != $past(outWave)));

  // R5: the running count stays inside the loaded span
  p_span_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ((cnt != '0) && (cnt <= reload) && (reload <= MAX_SPAN)));

  // R10: no tick, no write, no movement
  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tickEn && !strb.stop && !strb.start) |=> ($stable(cnt) && $stable(outWave)));

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CHANNEL_ID = 0,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              wrCtrl,
  input  logic [BYTE_W-1:0] wrData,
  output logic              outWave
);

  pitStrobeT strb;

  pit_ctrl #(
    .CHANNEL_ID(CHANNEL_ID),
    .BYTE_W(BYTE_W)
  ) ctrl_i (
    .clk(clk),
    .rst_n(rst_n),
    .wrEn(wrEn),
    .wrCtrl(wrCtrl),
    .wrData(wrData),
    .strb(strb)
  );

  pit_datapath #(
    .BYTE_W(BYTE_W)
  ) dp_i (
    .clk(clk),
    .rst_n(rst_n),
    .tickEn(tickEn),
    .wrData(wrData),
    .strb(strb),
    .outWave(outWave)
  );

endmodule

// File: tb/pit_channel_tb_top.sv
module pit_channel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrCtrl = 1'b0;
  logic [7:0] wrData = '0;
  logic       outWave;

  always #5 clk = ~clk;

  pit_channel dut_i (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wrEn(wrEn),
    .wrCtrl(wrCtrl), .wrData(wrData), .outWave(outWave)
  );

  typedef struct { bit expVal; string tag; } expItemT;
  expItemT expQ[$];

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // Reference model, written from the requirements
  bit mCfg = 0, mPtrHi = 0, mRun = 0, mSq = 0;
  int mLow = 0, mSpan = 2, mK = 0;

  function automatic bit modelOut();
    int ph;
    if (!mRun) return 1'b1;
    ph = mK % mSpan;
    if (mSq) return (ph < (mSpan + 1) / 2);
    return (ph != mSpan - 1);
  endfunction

  task automatic step(input bit tk, input bit we, input bit wc,
                      input logic [7:0] d, input string tag);
    int raw;
    @(negedge clk);
    tickEn = tk; wrEn = we; wrCtrl = wc; wrData = d;
    if (we && wc) begin
      if (d[7:6] == 2'd0 && d[5:4] == 2'b11 && (d[3:1] == 3'd2 || d[3:1] == 3'd3)) begin
        mCfg = 1; mRun = 0; mPtrHi = 0; mSq = (d[3:1] == 3'd3);
      end
    end else if (we && mCfg) begin
      if (!mPtrHi) begin
        mLow = d; mPtrHi = 1;
      end else begin
        raw = (int'(d) << 8) | mLow;
        mSpan = (raw == 0) ? 65536 : (raw == 1) ? 2 : raw;
        mRun = 1; mK = 0; mPtrHi = 0;
      end
    end else if (tk && mRun) begin
      mK++;
    end
    expQ.push_back('{expVal: modelOut(), tag: tag});
  endtask

  task automatic ticks(input int n, input int gap, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1, 0, 0, 8'h00, tag);
      for (int g = 0; g < gap; g++) step(0, 0, 0, 8'h00, tag);
    end
  endtask

  task automatic ctrlWr(input logic [7:0] d, input string tag);
    step(0, 1, 1, d, tag);
  endtask

  task automatic loadCount(input int n, input string tag);
    step(0, 1, 0, 8'(n & 8'hff), tag);
    step(0, 1, 0, 8'((n >> 8) & 8'hff), tag);
  endtask

  // Monitor: pops one expectation per cycle after the edge settles
  always begin
    @(posedge clk);
    #3;
    if (expQ.size() > 0) begin
      expItemT it;
      it = expQ.pop_front();
      nChecks++;
      if (outWave !== it.expVal) begin
        nFails++;
        $display("FAIL %s: outWave=%0b expected %0b at %0t", it.tag, outWave, it.expVal, $time);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset level
    nChecks++;
    if (outWave !== 1'b1) begin
      nFails++;
      $display("FAIL R1: outWave=%0b expected 1 in reset", outWave);
    end
    rst_n = 1'b1;
    step(0, 0, 0, 8'h00, "R1");
    // R1: counter bytes before any control word are ignored
    loadCount(3, "R1");
    ticks(8, 0, "R1");

    // R2, R6: rate generator, count 4
    ctrlWr(8'h34, "R2");
    ticks(3, 0, "R2");
    loadCount(4, "R4");
    ticks(12, 0, "R6");
    // R10: sparse ticks with idle cycles between them
    loadCount(5, "R4");
    ticks(11, 2, "R10");

    // R3: foreign channel, wrong access, unsupported mode, mid-period
    ctrlWr(8'h74, "R3");
    ticks(2, 0, "R3");
    ctrlWr(8'h14, "R3");
    ticks(2, 0, "R3");
    ctrlWr(8'h30, "R3");
    ticks(1, 0, "R3");
    ctrlWr(8'h3C, "R3");
    ticks(6, 0, "R3");

    // R4: low byte alone keeps running, high byte restarts at once
    loadCount(10, "R4");
    ticks(4, 0, "R4");
    step(0, 1, 0, 8'd3, "R4");
    ticks(3, 0, "R4");
    step(0, 1, 0, 8'd0, "R4");
    ticks(7, 0, "R4");

    // R2: accepted control word (bit 0 set) stops and holds high
    ctrlWr(8'h35, "R2");
    ticks(5, 0, "R2");
    // R9: count one behaves as two
    loadCount(1, "R9");
    ticks(7, 0, "R9");

    // R7: square wave, even count
    ctrlWr(8'h36, "R7");
    loadCount(6, "R7");
    ticks(18, 0, "R7");
    // R8: square wave, odd count
    loadCount(7, "R8");
    ticks(21, 1, "R8");
    // R9 in square mode
    loadCount(1, "R9");
    ticks(6, 0, "R9");

    // R5: zero count gives 65536, first toggle at tick 32768
    loadCount(0, "R5");
    ticks(32770, 0, "R5");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule